// File: doc/BRIEF.md
# Stereo Peak Level Monitor

This block watches two streams of signed 20-bit converter samples, one left and one right. For each channel it keeps a 3-bit code for the loudest peak seen since the status was last read. The samples are tapped before any limiter, so the codes show the true input level. On each valid sample the block takes the sample's magnitude and sorts it into one of eight bins: below -6 dBFS, one of six 1 dB bins from -6 up to -1 dBFS, or clipping. A channel's stored code changes only when the new bin is higher than the stored one.

A register bus reads both codes as one status byte. The read returns the codes and clears them. If a new peak arrives in the same cycle as the read, the read returns the old codes and the register then holds the new sample's bin, so no event is lost.

Top module: `stereo_peak_mon`

## Requirements
- R1: The magnitude of a sample is its two's complement absolute value. The most negative code (-524288) saturates to 524287, so it reads as clipping.
- R2: A magnitude of 524287 or more gives code 7 (clipping).
- R3: Below clipping the bin is set by the magnitude. At or above 467271 the code is 6, at or above 416455 it is 5, at or above 371167 it is 4, at or above 330799 it is 3, at or above 294831 it is 2, at or above 262767 it is 1, and below 262767 it is 0.
- R4: Between reads a channel's stored code never goes down. A valid sample replaces it only when the sample's bin is higher.
- R5: Each channel is binned and stored from its own samples only.
- R6: A read pulse on `rd_en` places the status byte on `rd_data` in the next cycle. The left code is in bits 6:4, the right code is in bits 2:0, and bits 7 and 3 are zero. `rd_data` then holds until the next read.
- R7: A read with no valid sample in the same cycle clears both stored codes to 0.
- R8: A read in the same cycle as a valid sample returns the codes from before that sample. Each channel then holds that sample's bin.
- R9: A sample with `smp_valid` low has no effect on the stored codes.
- R10: A synchronous active-high reset clears both codes and `rd_data` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Qualifies both sample inputs |
| smp_left | input | 20 | Left sample, signed two's complement |
| smp_right | input | 20 | Right sample, signed two's complement |
| rd_en | input | 1 | Status read pulse, clears both codes |
| rd_data | output | 8 | Status byte captured by the last read |

## Verification
The bench drives magnitudes one count below and exactly at each of the six thresholds. An off-by-one comparator would put one of these into the wrong bin. It drives both full-scale extremes, including -524288. A magnitude stage that wraps would report that code as near silence instead of clipping. Loud-then-quiet sequences catch a register that overwrites instead of keeping the maximum. A sample that arrives in the same cycle as a read catches a design that drops that sample or returns it early. Differing left and right stimuli expose swapped or crossed channel fields.

// File: rtl/spm_pkg.sv
package spm_pkg;
  localparam int CODE_W   = 3;
  localparam int NUM_BINS = 6;
  localparam int CH_NUM   = 2;
  localparam int FRAC_W   = 16;

  typedef logic [CODE_W-1:0] lvl_code_t;

  localparam lvl_code_t CODE_QUIET = '0;
  localparam lvl_code_t CODE_CLIP  = '1;

  // Amplitude ratio 10^(-k/20) in unsigned Q0.16, k in dB below full scale.
  function automatic longint unsigned db_ratio_q16(input int k);
    case (k)
      1:       return 64'd58409;
      2:       return 64'd52057;
      3:       return 64'd46396;
      4:       return 64'd41350;
      5:       return 64'd36854;
      default: return 64'd32846;
    endcase
  endfunction

  // Magnitude at which a sample reaches k dB below positive full scale.
  function automatic longint unsigned db_threshold(input int w, input int k);
    longint unsigned fs;
    fs = (64'd1 << (w - 1)) - 64'd1;
    return (fs * db_ratio_q16(k)) >> FRAC_W;
  endfunction
endpackage

// File: rtl/spm_magnitude.sv
module spm_magnitude #(
  parameter int SAMPLE_W = 20
) (
  input  logic [SAMPLE_W-1:0] sample,
  output logic [SAMPLE_W-2:0] mag
);
  localparam logic [SAMPLE_W-1:0] MOST_NEG = {1'b1, {(SAMPLE_W-1){1'b0}}};
  localparam logic [SAMPLE_W-2:0] POS_FS   = '1;

  logic [SAMPLE_W-1:0] negated;

  always_comb begin
    negated = (~sample) + 1'b1;
    if (!sample[SAMPLE_W-1]) begin
      mag = sample[SAMPLE_W-2:0];
    end else if (sample == MOST_NEG) begin
      mag = POS_FS;
    end else begin
      mag = negated[SAMPLE_W-2:0];
    end
  end
endmodule

// File: rtl/spm_binner.sv
module spm_binner
  import spm_pkg::*;
#(
  parameter int SAMPLE_W = 20
) (
  input  logic [SAMPLE_W-2:0] mag,
  output lvl_code_t           bin
);
  localparam logic [SAMPLE_W-2:0] POS_FS = '1;

  logic [NUM_BINS-1:0] at_or_above;

  // One comparator per 1 dB step; the set bits form a thermometer.
  for (genvar k = 1; k <= NUM_BINS; k++) begin : g_step
    localparam logic [SAMPLE_W-2:0] THR = (SAMPLE_W-1)'(db_threshold(SAMPLE_W, k));
    assign at_or_above[k-1] = (mag >= THR);
  end

  always_comb begin
    bin = CODE_QUIET;
    for (int i = 0; i < NUM_BINS; i++) begin
      bin = bin + lvl_code_t'(at_or_above[i]);
    end
    if (mag == POS_FS) begin
      bin = CODE_CLIP;
    end
  end
endmodule

// File: rtl/spm_sticky.sv
module spm_sticky
  import spm_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      upd,
  input  lvl_code_t bin,
  input  logic      clr,
  output lvl_code_t code
);
  always_ff @(posedge clk) begin
    if (rst) begin
      code <= CODE_QUIET;
    end else if (clr) begin
      code <= upd ? bin : CODE_QUIET;
    end else if (upd && (bin > code)) begin
      code <= bin;
    end
  end
endmodule

// File: rtl/stereo_peak_mon.sv
module stereo_peak_mon
  import spm_pkg::*;
#(
  parameter int SAMPLE_W = 20
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_left,
  input  logic [SAMPLE_W-1:0] smp_right,
  input  logic                rd_en,
  output logic [7:0]          rd_data
);
  logic [CH_NUM-1:0][SAMPLE_W-1:0] ch_sample;
  lvl_code_t                       ch_code [CH_NUM];
  lvl_code_t                       lvl_l;
  lvl_code_t                       lvl_r;

  assign ch_sample[0] = smp_left;
  assign ch_sample[1] = smp_right;

  for (genvar c = 0; c < CH_NUM; c++) begin : g_ch
    logic [SAMPLE_W-2:0] mag;
    lvl_code_t           bin;

    spm_magnitude #(.SAMPLE_W(SAMPLE_W)) mag_i (
      .sample (ch_sample[c]),
      .mag    (mag)
    );

    spm_binner #(.SAMPLE_W(SAMPLE_W)) bin_i (
      .mag (mag),
      .bin (bin)
    );

    spm_sticky hold_i (
      .clk  (clk),
      .rst  (rst),
      .upd  (smp_valid),
      .bin  (bin),
      .clr  (rd_en),
      .code (ch_code[c])
    );
  end

  assign lvl_l = ch_code[0];
  assign lvl_r = ch_code[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      rd_data <= {1'b0, lvl_l, 1'b0, lvl_r};
    end
  end
endmodule

// File: rtl/spm_checker.sv
module spm_checker #(
  parameter int SAMPLE_W = 20
) (
  input logic                clk,
  input logic                rst,
  input logic                smp_valid,
  input logic [SAMPLE_W-1:0] smp_left,
  input logic                rd_en,
  input logic [7:0]          rd_data,
  input logic [2:0]          lvl_l,
  input logic [2:0]          lvl_r
);
  localparam logic [SAMPLE_W-1:0] MOST_NEG = {1'b1, {(SAMPLE_W-1){1'b0}}};
  localparam logic [SAMPLE_W-1:0] MOST_POS = {1'b0, {(SAMPLE_W-1){1'b1}}};

  a_r10_reset_clear: assert property (@(posedge clk)
    rst |=> (rd_data == 8'd0 && lvl_l == 3'd0 && lvl_r == 3'd0));

  a_r6_read_byte: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_data == {1'b0, $past(lvl_l), 1'b0, $past(lvl_r)});

  a_r6_hold_byte: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));

  a_r4_no_decrease: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (lvl_l >= $past(lvl_l) && lvl_r >= $past(lvl_r)));

  a_r7_read_clears: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !smp_valid) |=> (lvl_l == 3'd0 && lvl_r == 3'd0));

  a_r9_invalid_ignored: assert property (@(posedge clk) disable iff (rst)
    (!rd_en && !smp_valid) |=> ($stable(lvl_l) && $stable(lvl_r)));

  a_r1_extremes_clip: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && (smp_left == MOST_NEG || smp_left == MOST_POS)) |=> lvl_l == 3'd7);
endmodule

bind stereo_peak_mon spm_checker #(.SAMPLE_W(SAMPLE_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .smp_valid (smp_valid),
  .smp_left  (smp_left),
  .rd_en     (rd_en),
  .rd_data   (rd_data),
  .lvl_l     (lvl_l),
  .lvl_r     (lvl_r)
);

// File: tb/stereo_peak_mon_tb_top.sv
module stereo_peak_mon_tb_top;
  localparam int W = 20;
  localparam int NV = 16;
  // Columns: left sample, right sample, expected left code, expected right code.
  localparam int VEC [NV][4] = '{
    '{0,        524287,   0, 7},
    '{262766,   -262767,  0, 1},
    '{262767,   262766,   1, 0},
    '{-262767,  294830,   1, 1},
    '{294831,   -330798,  2, 2},
    '{330799,   -330799,  3, 3},
    '{371166,   371167,   3, 4},
    '{371167,   416454,   4, 4},
    '{416455,   -416455,  5, 5},
    '{467270,   467271,   5, 6},
    '{467271,   -524287,  6, 7},
    '{524286,   -524288,  6, 7},
    '{524287,   100000,   7, 0},
    '{-524288,  -467271,  7, 6},
    '{-524287,  -300000,  7, 2},
    '{100000,   0,        0, 0}
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         smp_valid = 1'b0;
  logic [W-1:0] smp_left = '0;
  logic [W-1:0] smp_right = '0;
  logic         rd_en = 1'b0;
  logic [7:0]   rd_data;
  int           checks = 0;
  int           failures = 0;
  bit           done = 1'b0;

  always #2.5 clk = ~clk;

  stereo_peak_mon #(.SAMPLE_W(W)) dut_i (
    .clk       (clk),
    .rst       (rst),
    .smp_valid (smp_valid),
    .smp_left  (smp_left),
    .smp_right (smp_right),
    .rd_en     (rd_en),
    .rd_data   (rd_data)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input int l, input int r);
    @(negedge clk);
    smp_valid = 1'b1;
    smp_left  = W'(l);
    smp_right = W'(r);
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic read_status(output int lc, output int rc);
    @(negedge clk);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    lc = int'(rd_data[6:4]);
    rc = int'(rd_data[2:0]);
  endtask

  initial begin
    int lc, rc;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10: nothing recorded after reset
    check("R10 reset byte", int'(rd_data), 0);
    read_status(lc, rc);
    check("R10 left after reset", lc, 0);
    check("R10 right after reset", rc, 0);

    // R1 R2 R3 R5 R6: table walk, one sample then a read
    for (int i = 0; i < NV; i++) begin
      push(VEC[i][0], VEC[i][1]);
      read_status(lc, rc);
      check($sformatf("R3 left vec %0d", i), lc, VEC[i][2]);
      check($sformatf("R5 right vec %0d", i), rc, VEC[i][3]);
      check($sformatf("R6 spare bits vec %0d", i), int'({rd_data[7], rd_data[3]}), 0);
    end

    // R4: loud then quiet keeps the loud bin
    push(416455, 262767);
    push(262767, 524287);
    push(0, 0);
    read_status(lc, rc);
    check("R4 left keeps max", lc, 5);
    check("R4 right keeps max", rc, 7);

    // R7: a second read sees the cleared codes
    read_status(lc, rc);
    check("R7 left cleared", lc, 0);
    check("R7 right cleared", rc, 0);

    // R6: byte holds while no read is issued
    push(330799, 0);
    repeat (4) @(negedge clk);
    check("R6 byte held", int'(rd_data), 0);

    // R9: invalid loud samples change nothing
    @(negedge clk);
    smp_left = W'(524287);
    smp_right = W'(524287);
    repeat (3) @(negedge clk);
    read_status(lc, rc);
    check("R9 left ignores invalid", lc, 3);
    check("R9 right ignores invalid", rc, 0);

    // R8: sample in the read cycle is kept for the next read
    push(467271, 371167);
    @(negedge clk);
    rd_en = 1'b1;
    smp_valid = 1'b1;
    smp_left = W'(262767);
    smp_right = W'(-524288);
    @(negedge clk);
    rd_en = 1'b0;
    smp_valid = 1'b0;
    check("R8 old left returned", int'(rd_data[6:4]), 6);
    check("R8 old right returned", int'(rd_data[2:0]), 4);
    read_status(lc, rc);
    check("R8 new left kept", lc, 1);
    check("R8 new right kept", rc, 7);

    // R10: reset mid-run clears codes and byte
    push(524287, 524287);
    read_status(lc, rc);
    push(524287, 524287);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R10 byte cleared", int'(rd_data), 0);
    read_status(lc, rc);
    check("R10 left cleared", lc, 0);
    check("R10 right cleared", rc, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule